// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block collects a parameterised set of level-sensitive peripheral interrupt lines (64, 96, 128 or 160) and drives one interrupt line toward each CPU. The inputs are treated as 32-bit groups, from 2 to 5 of them. Every CPU owns a private copy of the mask state. A peripheral reaches a CPU only when its bit is unmasked in that CPU's copy. Unmasking the same bit in several copies sends the interrupt to several CPUs at once.

Software works through a 32-bit register port with one select line per CPU bank. Each bank shows the synchronised raw input levels, its current mask bits, and two write-only strobe registers. A 1 written to a strobe register masks or unmasks that bit without a read-modify-write. The block has no priority encoder and no queue of pending sources. A handler reads every status word to find out which sources are pending.

Top module: `irq_l1_agg`

## Requirements
- R1: Each input passes through two flip-flops before it is visible. A level applied before clock edge k reads back in the status register after edge k+1 and not before. Status word g, bit j carries input 32*g+j.
- R2: A write to a status register changes nothing that is readable.
- R3: After reset every mask bit of every bank is 1 and every `cpu_irq` bit is 0.
- R4: Writing a word to an unmask-strobe register clears exactly the mask bits where the word has a 1. Bits written as 0 keep their value.
- R5: Writing a word to a mask-strobe register sets exactly the mask bits where the word has a 1. Bits written as 0 keep their value.
- R6: A bus write changes only the banks whose `bus_sel` bit is 1. The other CPUs' masks and outputs are unaffected.
- R7: `cpu_irq[c]` is a register. It is 1 one clock after some synchronised input is 1 while bank c has that bit unmasked. It is 0 whenever all of bank c's mask bits are 1.
- R8: An input held high keeps its unmasked CPU output asserted. Three clocks after the input falls, the output falls.
- R9: Within a bank, with W groups, register word index i = `bus_addr[ADDR_W-1:2]` decodes as follows. Indices 0..W-1 are status, W..2W-1 are mask state (1 means masked), 2W..3W-1 are mask strobes and 3W..4W-1 are unmask strobes. Strobe registers and indices of 4W or above read as 0. Read data is combinational from `bus_sel` and `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IRQ | Level-sensitive peripheral interrupt lines |
| bus_sel | input | NUM_CPU | One select per CPU register bank (one-hot for reads) |
| bus_wr | input | 1 | Write strobe, 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address inside the selected bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data from the selected bank |
| cpu_irq | output | NUM_CPU | Interrupt request toward each CPU |

## Verification
The hardest case is routing a single source to two CPUs while each CPU's mask moves independently. Another is the third delay stage on a falling input, which must not cut the output short. The stimulus unmasks one source in one bank and checks that the other CPU stays quiet. It then unmasks the same source in the second bank, drops the input, and re-masks it in only one bank. A behavioural model compares both outputs on every clock. Explicit checks also land on the exact edge where each output should change. The top bit of the last group is routed separately, so the highest status and mask words are exercised.

// File: rtl/irq_l1_pkg.sv
package irq_l1_pkg;

    localparam int WORD_BITS = 32;

    typedef logic [WORD_BITS-1:0] word_t;

    typedef enum logic [2:0] {
        RG_STATUS,
        RG_MASK,
        RG_SET,
        RG_CLEAR,
        RG_NONE
    } region_e;

    function automatic region_e region_of(int idx, int words);
        if (idx < words)          return RG_STATUS;
        else if (idx < 2 * words) return RG_MASK;
        else if (idx < 3 * words) return RG_SET;
        else if (idx < 4 * words) return RG_CLEAR;
        else                      return RG_NONE;
    endfunction

    function automatic int group_of(int idx, int words);
        return idx % words;
    endfunction

endpackage

// File: rtl/irq_l1_sync.sv
module irq_l1_sync #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign synced = st_q.s2;

endmodule

// File: rtl/irq_l1_bank.sv
module irq_l1_bank
    import irq_l1_pkg::*;
#(
    parameter int WORDS = 2,
    parameter int IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  wr,
    input  logic [IDX_W-1:0]      idx,
    input  word_t                 wdata,
    input  logic [WORDS-1:0][31:0] pending,
    output word_t                 rdata,
    output logic                  irq
);

    typedef struct packed {
        logic [WORDS-1:0][31:0] mask;
        logic                   irq;
    } bank_t;

    bank_t            st_d, st_q;
    region_e          region;
    int               grp;
    logic [WORDS-1:0] set_w;
    logic [WORDS-1:0] clr_w;

    always_comb begin
        region = region_of(int'(idx), WORDS);
        grp    = group_of(int'(idx), WORDS);
        for (int k = 0; k < WORDS; k++) begin
            set_w[k] = sel && wr && (region == RG_SET)   && (grp == k);
            clr_w[k] = sel && wr && (region == RG_CLEAR) && (grp == k);
        end
    end

    // next state: set first, clear applied last so it wins on a shared bit
    always_comb begin
        st_d = st_q;
        for (int k = 0; k < WORDS; k++) begin
            st_d.mask[k] = (st_q.mask[k] | (set_w[k] ? wdata : '0))
                           & ~(clr_w[k] ? wdata : '0);
        end
        st_d.irq = |(pending & ~st_q.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (grp == k) begin
                if (region == RG_STATUS) rdata = pending[k];
                if (region == RG_MASK)   rdata = st_q.mask[k];
            end
        end
    end

    assign irq = st_q.irq;

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |=> !st_q.irq);

    for (genvar k = 0; k < WORDS; k++) begin : g_chk
        assert_set_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (set_w[k] && !clr_w[k]) |=> ((st_q.mask[k] & $past(wdata)) == $past(wdata)));
        assert_clear_unmasks_R4: assert property (@(posedge clk) disable iff (!rst_n)
            clr_w[k] |=> ((st_q.mask[k] & $past(wdata)) == '0));
        assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(sel && wr) |=> (st_q.mask[k] == $past(st_q.mask[k])));
    end

endmodule

// File: rtl/irq_l1_agg.sv
module irq_l1_agg
    import irq_l1_pkg::*;
#(
    parameter  int NUM_IRQ = 64,
    parameter  int NUM_CPU = 2,
    localparam int WORDS   = NUM_IRQ / 32,
    localparam int IDX_W   = $clog2(4 * WORDS),
    localparam int ADDR_W  = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_CPU-1:0] bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);

    if (!(NUM_IRQ == 64 || NUM_IRQ == 96 || NUM_IRQ == 128 || NUM_IRQ == 160)) begin : g_bad
        $error("NUM_IRQ must be 64, 96, 128 or 160");
    end

    logic [NUM_IRQ-1:0]     synced;
    logic [WORDS-1:0][31:0] pending;
    word_t                  bank_rd [NUM_CPU];

    irq_l1_sync #(.N(NUM_IRQ)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (irq_in),
        .synced (synced)
    );

    assign pending = synced;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        irq_l1_bank #(.WORDS(WORDS), .IDX_W(IDX_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (bus_sel[c]),
            .wr      (bus_wr),
            .idx     (bus_addr[ADDR_W-1:2]),
            .wdata   (bus_wdata),
            .pending (pending),
            .rdata   (bank_rd[c]),
            .irq     (cpu_irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (bus_sel[c]) bus_rdata = bus_rdata | bank_rd[c];
        end
    end

endmodule

// File: tb/irq_l1_agg_test.sv
module irq_l1_agg_test;

    localparam int NI = 96;
    localparam int NC = 2;
    localparam int W  = NI / 32;
    localparam int AW = $clog2(4 * W) + 2;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NI-1:0] irq_in = '0;
    logic [NC-1:0] bus_sel = '0;
    logic          bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] cpu_irq;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    int  cycles = 0;

    irq_l1_agg #(.NUM_IRQ(NI), .NUM_CPU(NC)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    always #5 clk = ~clk;

    // behavioural reference
    logic [NI-1:0] m_s1, m_s2;
    logic [NI-1:0] m_mask [NC];
    logic [NC-1:0] m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_irq = '0;
            for (int c = 0; c < NC; c++) m_mask[c] = '1;
        end else begin
            for (int c = 0; c < NC; c++) m_irq[c] = |(m_s2 & ~m_mask[c]);
            for (int c = 0; c < NC; c++) begin
                if (bus_sel[c] && bus_wr) begin
                    int i;
                    i = int'(bus_addr) / 4;
                    if (i >= 2*W && i < 3*W) m_mask[c][(i-2*W)*32 +: 32] = m_mask[c][(i-2*W)*32 +: 32] | bus_wdata;
                    if (i >= 3*W && i < 4*W) m_mask[c][(i-3*W)*32 +: 32] = m_mask[c][(i-3*W)*32 +: 32] & ~bus_wdata;
                end
            end
            m_s2 = m_s1;
            m_s1 = irq_in;
        end
    end

    function automatic logic [31:0] model_read(int c, int i);
        if (i < W)     return m_s2[i*32 +: 32];
        if (i < 2*W)   return m_mask[c][(i-W)*32 +: 32];
        return '0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock output comparison against the model (R7)
    always @(negedge clk) begin
        if (rst_n && !done) check("R7 per-clock cpu_irq", 32'(cpu_irq), 32'(m_irq));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic bus_write(int c, int i, logic [31:0] d);
        bus_sel = NC'(1 << c); bus_wr = 1; bus_addr = AW'(i * 4); bus_wdata = d;
        @(negedge clk);
        bus_sel = '0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic bus_read(int c, int i, string tag, logic [31:0] exp);
        bus_sel = NC'(1 << c); bus_wr = 0; bus_addr = AW'(i * 4);
        #1;
        check(tag, bus_rdata, exp);
        check({tag, " model"}, bus_rdata, model_read(c, i));
        @(negedge clk);
        bus_sel = '0;
    endtask

    localparam logic [NI-1:0] PAT = 96'h0000_0000_0000_0100_A500_0021;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R3: reset state
        check("R3 cpu_irq after reset", 32'(cpu_irq), 32'h0);
        for (int c = 0; c < NC; c++)
            for (int g = 0; g < W; g++) bus_read(c, W + g, "R3 mask word", 32'hFFFF_FFFF);

        // R1: two-stage latency and bit placement
        irq_in = PAT;
        @(negedge clk);
        bus_read(0, 0, "R1 status before second edge", 32'h0);
        bus_read(0, 0, "R1 status word0", 32'hA500_0021);
        bus_read(1, 1, "R1 status word1", 32'h0000_0100);
        check("R7 all masked quiet", 32'(cpu_irq), 32'h0);

        // R2: status writes ignored
        bus_write(0, 0, 32'hFFFF_FFFF);
        bus_read(0, 0, "R2 status after write", 32'hA500_0021);
        bus_read(0, W, "R2 mask after status write", 32'hFFFF_FFFF);

        // R4: unmask bit 5 in CPU0
        bus_write(0, 3*W, 32'h0000_0020);
        check("R7 not yet asserted", 32'(cpu_irq), 32'h0);
        @(negedge clk);
        check("R7 cpu0 asserted one clock later", 32'(cpu_irq), 32'h1);
        check("R6 cpu1 untouched", 32'(cpu_irq[1]), 32'h0);
        bus_read(0, W, "R4 cpu0 mask word0", 32'hFFFF_FFDF);
        bus_read(1, W, "R6 cpu1 mask word0", 32'hFFFF_FFFF);

        // R4: zero bits have no effect
        bus_write(0, 3*W + 1, 32'h0);
        bus_read(0, W + 1, "R4 zero write keeps mask", 32'hFFFF_FFFF);

        // R6: route same source to CPU1 too
        bus_write(1, 3*W, 32'h0000_0020);
        @(negedge clk);
        check("R6 both CPUs asserted", 32'(cpu_irq), 32'h3);

        // R8: held level stays; falling input drops after three clocks
        repeat (4) @(negedge clk);
        check("R8 held level", 32'(cpu_irq), 32'h3);
        irq_in[5] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 still high two clocks after fall", 32'(cpu_irq), 32'h3);
        @(negedge clk);
        check("R8 low three clocks after fall", 32'(cpu_irq), 32'h0);

        // R5: re-raise, mask in CPU0 only
        irq_in[5] = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 re-raised", 32'(cpu_irq), 32'h3);
        bus_write(0, 2*W, 32'h0000_0020);
        @(negedge clk);
        check("R5 cpu0 masked, cpu1 kept", 32'(cpu_irq), 32'h2);
        bus_read(0, W, "R5 cpu0 mask restored", 32'hFFFF_FFFF);
        bus_write(0, 2*W, 32'h0);
        bus_read(0, W, "R5 zero write keeps mask", 32'hFFFF_FFFF);

        // R9: top bit of last group, register map edges
        bus_write(1, 2*W, 32'h0000_0020);
        bus_write(1, 4*W - 1, 32'h8000_0000);
        @(negedge clk);
        check("R9 no source yet on bit 95", 32'(cpu_irq), 32'h0);
        irq_in[NI-1] = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 bit 95 routes to cpu1", 32'(cpu_irq), 32'h2);
        bus_read(1, W - 1, "R9 status top word", 32'h8000_0000);
        bus_read(1, 2*W - 1, "R9 mask top word", 32'h7FFF_FFFF);
        bus_read(1, 2*W, "R9 set strobe reads zero", 32'h0);
        bus_read(1, 3*W, "R9 clear strobe reads zero", 32'h0);
        bus_read(1, 4*W, "R9 unused index reads zero", 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule